// File: doc/BRIEF.md
# Synchronous Multi-Channel PWM Group

This block produces four pulse-width-modulated outputs. Each channel has its own counter and its own settings: a prescaler tap, a period, a duty value and an alignment mode. Any channel can be made a member of a single synchronous group. Channel 0 leads that group. A member ignores its own tap, period and alignment and runs from channel 0's values, so all members that start together count in lockstep. The duty value always stays per channel.

Software loads settings through a shared write-data bus with a per-channel load strobe. Group membership is written as a mask with its own load strobe. Channels are switched on and off with single-cycle enable and disable masks. Raising channel 0's enable starts the whole group in one cycle, and raising its disable stops the whole group in one cycle. Every pin is plain control or status. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `pwm_sync_grp`

## Requirements
- R1: After reset every channel is off, every output is low, no channel is grouped and all settings are zero.
- R2: In left alignment (`cfg_mid`=0) a running counter goes 0,1,…,period and then back to 0. A channel's output is high only while it is on and its counter is below its duty value.
- R3: In center alignment (`cfg_mid`=1) a running counter rises from 0 to the period and then falls back to 0, one step per tick, giving a cycle of 2×period ticks.
- R4: A tap value n (0..7) advances a counter only on ticks of a shared free-running divider. Tap 0 ticks on every clock. Tap n>0 ticks when the low n bits of the divider are all ones, which is once every 2^n clocks. The divider starts at 0 after reset.
- R5: A grouped channel uses channel 0's tap, period and alignment. Its own copies of those three settings have no effect on its output. Its own duty value still applies.
- R6: Setting the group bit of any channel makes channel 0 a group member, even when channel 0's own bit is clear.
- R7: An enable of channel 0 turns on every group member at the same edge, with all counters at 0. A disable of channel 0 turns off every group member at the same edge.
- R8: A group member other than channel 0 can still be turned on or off alone through its own bit in the enable or disable mask.
- R9: A group-mask load changes a channel's group bit only if that channel is off at that edge. For a channel that is on, the load is ignored.
- R10: When enable and disable reach a channel in the same cycle, either directly or through channel 0, the channel ends up off.
- R11: A channel that is turned on starts its counter at 0. This holds even for a group member whose leader is already running.
- R12: A channel outside the group runs from its own settings and is not touched by channel 0's enable or disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ld | input | NCH | Per-channel strobe that loads the cfg_* bus into that channel |
| cfg_psel | input | 3 | Prescaler tap n, giving a divide-by-2^n tick |
| cfg_prd | input | 16 | Period |
| cfg_dty | input | 16 | Duty compare value |
| cfg_mid | input | 1 | 0 = left aligned, 1 = center aligned |
| grp_ld | input | 1 | Strobe that loads grp_mask |
| grp_mask | input | NCH | Group-membership bit per channel |
| en_mask | input | NCH | Single-cycle enable strobes |
| dis_mask | input | NCH | Single-cycle disable strobes |
| chan_on | output | NCH | Channels currently on |
| pwm_out | output | NCH | PWM outputs |

## Verification
Every strobe is sampled at one clock edge. Its effect is visible on `chan_on` and `pwm_out` straight after that same edge, because the outputs decode registered state with no further register. A counter first moves at the second edge after its enable, and then only on edges where its selected tap ticks. The bench computes each cycle's expected outputs at the edge from the inputs it drove, queues them, and compares them against the design on the following falling edge, so each result is checked in the cycle it becomes due.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  localparam int CNT_W  = 16;
  localparam int PSEL_W = 3;
  localparam int NTAP   = 1 << PSEL_W;

  typedef enum logic {
    ALIGN_EDGE = 1'b0,
    ALIGN_MID  = 1'b1
  } align_e;

  typedef struct packed {
    logic [PSEL_W-1:0] psel;
    logic [CNT_W-1:0]  prd;
    logic [CNT_W-1:0]  dty;
    align_e            aln;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_presc.sv
// Shared free-running divider; tap n pulses once every 2^n clocks.
module pwm_presc #(
  parameter int NSEL = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [NSEL-1:0] tick
);
  localparam int DW = (NSEL > 1) ? NSEL - 1 : 1;

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_q + 1'b1;
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_tap
    if (g == 0) begin : g_every
      assign tick[g] = 1'b1;
    end else begin : g_div
      assign tick[g] = &div_q[g-1:0];
    end
  end
endmodule

// File: rtl/pwm_grp_ctl.sv
// Group membership and channel run state.
module pwm_grp_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           grp_ld,
  input  logic [NCH-1:0] grp_mask,
  input  logic [NCH-1:0] en_mask,
  input  logic [NCH-1:0] dis_mask,
  output logic [NCH-1:0] run_d,
  output logic [NCH-1:0] run_q,
  output logic [NCH-1:0] grp_q,
  output logic [NCH-1:0] grp_eff
);
  // the leader joins whenever any channel is grouped
  always_comb begin
    grp_eff    = grp_q;
    grp_eff[0] = |grp_q;
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      logic turn_on, turn_off;
      turn_on  = en_mask[i]  | (en_mask[0]  & grp_eff[i]);
      turn_off = dis_mask[i] | (dis_mask[0] & grp_eff[i]);
      run_d[i] = (run_q[i] | turn_on) & ~turn_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      grp_q <= '0;
    end else begin
      run_q <= run_d;
      for (int i = 0; i < NCH; i++) begin
        if (grp_ld && !run_q[i]) grp_q[i] <= grp_mask[i];
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
// One channel counter with left or center alignment and a duty compare.
module pwm_chan
  import pwm_sync_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_d,
  input  logic             run_q,
  input  logic             tick,
  input  logic [CNT_W-1:0] prd,
  input  logic [CNT_W-1:0] dty,
  input  align_e           aln,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt_q;
  logic             down_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (!run_d) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (run_q && tick) begin
      if (aln == ALIGN_EDGE) begin
        down_q <= 1'b0;
        cnt_q  <= (cnt_q >= prd) ? '0 : cnt_q + 1'b1;
      end else if (!down_q) begin
        if (cnt_q >= prd) begin
          down_q <= 1'b1;
          cnt_q  <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == '0) begin
          down_q <= 1'b0;
          cnt_q  <= (prd == '0) ? '0 : CNT_W'(1);
        end else begin
          cnt_q  <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pwm = run_q && (cnt_q < dty);
endmodule

// File: rtl/pwm_sync_grp.sv
module pwm_sync_grp
  import pwm_sync_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cfg_ld,
  input  logic [PSEL_W-1:0] cfg_psel,
  input  logic [CNT_W-1:0]  cfg_prd,
  input  logic [CNT_W-1:0]  cfg_dty,
  input  logic              cfg_mid,
  input  logic              grp_ld,
  input  logic [NCH-1:0]    grp_mask,
  input  logic [NCH-1:0]    en_mask,
  input  logic [NCH-1:0]    dis_mask,
  output logic [NCH-1:0]    chan_on,
  output logic [NCH-1:0]    pwm_out
);
  logic [NTAP-1:0] tick;
  logic [NCH-1:0]  run_d, run_q, grp_q, grp_eff;
  chan_cfg_t       cfg_q [NCH];

  pwm_presc #(.NSEL(NTAP)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pwm_grp_ctl #(.NCH(NCH)) u_ctl (
    .clk(clk), .rst_n(rst_n), .grp_ld(grp_ld), .grp_mask(grp_mask),
    .en_mask(en_mask), .dis_mask(dis_mask),
    .run_d(run_d), .run_q(run_q), .grp_q(grp_q), .grp_eff(grp_eff)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chan_cfg_t use_cfg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[c] <= '0;
      end else if (cfg_ld[c]) begin
        cfg_q[c].psel <= cfg_psel;
        cfg_q[c].prd  <= cfg_prd;
        cfg_q[c].dty  <= cfg_dty;
        cfg_q[c].aln  <= align_e'(cfg_mid);
      end
    end

    // members take the leader's timing, keep their own duty
    always_comb begin
      use_cfg = cfg_q[c];
      if (grp_eff[c]) begin
        use_cfg.psel = cfg_q[0].psel;
        use_cfg.prd  = cfg_q[0].prd;
        use_cfg.aln  = cfg_q[0].aln;
      end
    end

    pwm_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .run_d(run_d[c]), .run_q(run_q[c]),
      .tick(tick[use_cfg.psel]),
      .prd(use_cfg.prd), .dty(use_cfg.dty), .aln(use_cfg.aln),
      .pwm(pwm_out[c])
    );
  end

  assign chan_on = run_q;
endmodule

// File: rtl/pwm_sync_chk.sv
module pwm_sync_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] en_mask,
  input logic [NCH-1:0] dis_mask,
  input logic [NCH-1:0] chan_on,
  input logic [NCH-1:0] pwm_out,
  input logic [NCH-1:0] grp_q,
  input logic [NCH-1:0] grp_eff
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mask[g] && dis_mask[g]) |=> !chan_on[g]); // R10
    AST_GROUP_START: assert property (@(posedge clk) disable iff (!rst_n)
      (en_mask[0] && !dis_mask[0] && grp_eff[g] && !dis_mask[g]) |=> chan_on[g]); // R7
    AST_GROUP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_mask[0] && grp_eff[g]) |=> !chan_on[g]); // R7
    AST_MEMBER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      chan_on[g] |=> $stable(grp_q[g])); // R9
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_on[g] |-> !pwm_out[g]); // R2
  end
endmodule

bind pwm_sync_grp pwm_sync_chk #(.NCH(NCH)) u_pwm_sync_chk (
  .clk(clk), .rst_n(rst_n), .en_mask(en_mask), .dis_mask(dis_mask),
  .chan_on(chan_on), .pwm_out(pwm_out), .grp_q(grp_q), .grp_eff(grp_eff)
);

// File: tb/test_pwm_sync_grp.sv
module test_pwm_sync_grp;
  localparam int NCH = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NCH-1:0]   cfg_ld = '0;
  logic [2:0]       cfg_psel = '0;
  logic [15:0]      cfg_prd = '0;
  logic [15:0]      cfg_dty = '0;
  logic             cfg_mid = 1'b0;
  logic             grp_ld = 1'b0;
  logic [NCH-1:0]   grp_mask = '0;
  logic [NCH-1:0]   en_mask = '0;
  logic [NCH-1:0]   dis_mask = '0;
  logic [NCH-1:0]   chan_on, pwm_out;

  always #5 clk = ~clk;

  pwm_sync_grp #(.NCH(NCH)) i_pwm_sync_grp (
    .clk(clk), .rst_n(rst_n), .cfg_ld(cfg_ld), .cfg_psel(cfg_psel),
    .cfg_prd(cfg_prd), .cfg_dty(cfg_dty), .cfg_mid(cfg_mid),
    .grp_ld(grp_ld), .grp_mask(grp_mask), .en_mask(en_mask),
    .dis_mask(dis_mask), .chan_on(chan_on), .pwm_out(pwm_out)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;
  string cur_req = "R1";

  logic [7:0] exp_q [$];
  string      tag_q [$];

  // reference model built from the requirements
  logic [6:0]  m_div;
  logic [3:0]  m_on, m_grp;
  logic [15:0] m_cnt [NCH];
  logic        m_down [NCH];
  logic [2:0]  m_ps [NCH];
  logic [15:0] m_prd [NCH];
  logic [15:0] m_dty [NCH];
  logic        m_mid [NCH];

  always @(posedge clk) begin
    logic [3:0] eff, nxt, ex;
    if (!rst_n) begin
      m_div = '0; m_on = '0; m_grp = '0;
      for (int i = 0; i < NCH; i++) begin
        m_cnt[i] = '0; m_down[i] = 1'b0; m_ps[i] = '0;
        m_prd[i] = '0; m_dty[i] = '0; m_mid[i] = 1'b0;
      end
    end else begin
      eff = m_grp; eff[0] = |m_grp;
      for (int i = 0; i < NCH; i++)
        nxt[i] = (m_on[i] | en_mask[i] | (en_mask[0] & eff[i]))
                 & ~(dis_mask[i] | (dis_mask[0] & eff[i]));
      for (int i = 0; i < NCH; i++) begin
        int src, msk;
        bit tk;
        src = eff[i] ? 0 : i;
        msk = (1 << m_ps[src]) - 1;
        tk  = ((int'(m_div) & msk) == msk);
        if (!nxt[i]) begin
          m_cnt[i] = '0; m_down[i] = 1'b0;
        end else if (m_on[i] && tk) begin
          if (!m_mid[src]) begin
            m_down[i] = 1'b0;
            m_cnt[i]  = (m_cnt[i] >= m_prd[src]) ? 16'd0 : m_cnt[i] + 16'd1;
          end else if (!m_down[i]) begin
            if (m_cnt[i] >= m_prd[src]) begin
              m_down[i] = 1'b1;
              m_cnt[i]  = (m_cnt[i] == 0) ? 16'd0 : m_cnt[i] - 16'd1;
            end else m_cnt[i] = m_cnt[i] + 16'd1;
          end else begin
            if (m_cnt[i] == 0) begin
              m_down[i] = 1'b0;
              m_cnt[i]  = (m_prd[src] == 0) ? 16'd0 : 16'd1;
            end else m_cnt[i] = m_cnt[i] - 16'd1;
          end
        end
      end
      if (grp_ld)
        for (int i = 0; i < NCH; i++) if (!m_on[i]) m_grp[i] = grp_mask[i];
      m_on = nxt;
      for (int i = 0; i < NCH; i++)
        if (cfg_ld[i]) begin
          m_ps[i] = cfg_psel; m_prd[i] = cfg_prd;
          m_dty[i] = cfg_dty; m_mid[i] = cfg_mid;
        end
      m_div = m_div + 7'd1;
    end
    for (int i = 0; i < NCH; i++) ex[i] = m_on[i] && (m_cnt[i] < m_dty[i]);
    exp_q.push_back({m_on, ex});
    tag_q.push_back(cur_req);
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (!done && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({chan_on, pwm_out} !== e) begin
        n_bad++;
        $display("FAIL %s t=%0t on/pwm actual=%b/%b expected=%b/%b",
                 t, $time, chan_on, pwm_out, e[7:4], e[3:0]);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_cfg(int ch, int ps, int prd, int dty, bit mid);
    cfg_ld = '0; cfg_ld[ch] = 1'b1;
    cfg_psel = 3'(ps); cfg_prd = 16'(prd); cfg_dty = 16'(dty); cfg_mid = mid;
    @(negedge clk);
    cfg_ld = '0;
  endtask

  task automatic strobe(logic [3:0] en, logic [3:0] dis);
    en_mask = en; dis_mask = dis;
    @(negedge clk);
    en_mask = '0; dis_mask = '0;
  endtask

  task automatic load_grp(logic [3:0] m);
    grp_ld = 1'b1; grp_mask = m;
    @(negedge clk);
    grp_ld = 1'b0;
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R2: left aligned, own settings
    cur_req = "R2";
    load_cfg(2, 0, 5, 2, 0);
    strobe(4'b0100, 4'b0000);
    idle(14);
    // R3: center aligned
    cur_req = "R3";
    load_cfg(3, 0, 4, 3, 1);
    strobe(4'b1000, 4'b0000);
    idle(18);
    // R4: prescaler taps 2 and 1
    cur_req = "R4";
    strobe(4'b0000, 4'b0100);
    load_cfg(2, 2, 3, 2, 0);
    strobe(4'b0100, 4'b0000);
    idle(30);
    load_cfg(3, 1, 3, 2, 1);
    idle(20);
    // R6: only channel 1 grouped, leader bit clear
    cur_req = "R6";
    strobe(4'b0000, 4'b0100);
    load_grp(4'b0010);
    load_cfg(0, 0, 6, 3, 0);
    load_cfg(1, 3, 2, 4, 1);
    // R7 / R5: leader enable starts the group, member uses leader timing
    cur_req = "R7";
    strobe(4'b0001, 4'b0000);
    cur_req = "R5";
    idle(20);
    // R12: ungrouped channel 3 keeps running through group stop
    cur_req = "R12";
    strobe(4'b0000, 4'b0001);
    idle(6);
    // R8: member enabled and disabled alone
    cur_req = "R8";
    strobe(4'b0010, 4'b0000);
    idle(5);
    strobe(4'b0000, 4'b0010);
    idle(3);
    // R11: member joins a running leader from zero
    cur_req = "R11";
    strobe(4'b0001, 4'b0010);
    idle(4);
    strobe(4'b0010, 4'b0000);
    idle(12);
    // R9: membership write ignored while on, honoured while off
    cur_req = "R9";
    load_grp(4'b0000);
    strobe(4'b0000, 4'b0001);
    idle(3);
    load_grp(4'b0000);
    strobe(4'b0001, 4'b0000);
    idle(8);
    // R10: enable and disable together
    cur_req = "R10";
    strobe(4'b0100, 4'b0100);
    idle(3);
    load_grp(4'b0100);
    strobe(4'b0000, 4'b0001);
    load_grp(4'b0100);
    strobe(4'b0001, 4'b0001);
    idle(4);
    strobe(4'b0001, 4'b0000);
    idle(10);
    cur_req = "R1";
    rst_n = 1'b0;
    idle(3);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule